// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside a small processor core and decides which clocks run. It keeps the core in one of four modes: run, wait, stop and background (debug halt). The core asks for wait or stop with a one-cycle strobe. The block then drops registered enables for the core clock, the peripheral clocks, the oscillator and a minimal always-alive clock. Interrupts, an external wake line, an internal periodic tick and debug commands bring the core back out. The block also holds the interrupt mask bit, because entering wait has to clear it.

Wait stops only the core clock. Any pending interrupt ends it, and a debug command can end it instead by sending the core straight into background mode. Stop halts everything by default. A configuration bit keeps the minimal clock alive so that the periodic tick can wake the part. A debug-enable bit keeps the oscillator and the minimal clock running so that an attached debug host stays connected. The external wake and tick inputs arrive from other clock domains and pass through a synchronizer of parameterised depth.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge `mode` becomes 00 (run), or 11 (background) if `boot_bkg` is high. `mask_bit` becomes 1 and all four clock enables become 1.
- R2: In run mode, `wait_req` moves the block to wait (01) on the next edge. It takes priority over `stop_req` sampled at the same edge. In wait, `cpu_clk_en` is 0 and the peripheral, oscillator and minimal enables stay 1.
- R3: In wait mode, `irq_pend` returns the block to run on the next edge and turns `cpu_clk_en` on again.
- R4: `bdm_cmd` with `dbg_en` high moves the block from run or wait to background (11). In wait it wins over `irq_pend`. With `dbg_en` low the command has no effect.
- R5: In run mode, `stop_req` without `wait_req` moves the block to stop (10). In stop, `cpu_clk_en` and `per_clk_en` are 0. `osc_en` equals `dbg_en`. `min_clk_en` equals `keep_min_clk` OR `dbg_en`.
- R6: A high level on `ext_wake` ends stop on edge WAKE_SYNC+1 after it is first sampled. `irq_pend` has no effect in stop.
- R7: `tick_wake`, delayed through the same synchronizer, ends stop only when `keep_min_clk` is 1. Otherwise it has no effect.
- R8: In background mode `cpu_clk_en` is 1. `bkg_go` returns the block to run on the next edge.
- R9: `mask_bit` is set by `mask_set` and cleared by `mask_clr`, with set winning. Entry into wait clears it, and this overrides `mask_set`.
- R10: Every output is a register. It reflects the mode chosen at an edge and the `dbg_en` and `keep_min_clk` values sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_bkg | input | 1 | Reset into background mode |
| wait_req | input | 1 | Core request strobe for wait |
| stop_req | input | 1 | Core request strobe for stop |
| irq_pend | input | 1 | Any interrupt pending |
| ext_wake | input | 1 | External wake line (asynchronous) |
| tick_wake | input | 1 | Internal periodic wake (asynchronous) |
| bdm_cmd | input | 1 | Debug command requesting background |
| bkg_go | input | 1 | Debug command resuming execution |
| dbg_en | input | 1 | Debug feature enabled |
| keep_min_clk | input | 1 | Keep minimal clock alive in stop |
| mask_set | input | 1 | Core sets the interrupt mask |
| mask_clr | input | 1 | Core clears the interrupt mask |
| mode | output | 2 | 00 run, 01 wait, 10 stop, 11 background |
| mask_bit | output | 1 | Interrupt mask bit |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| min_clk_en | output | 1 | Minimal clock enable |

## Verification
The bench builds the block with the default WAKE_SYNC of 2. At that depth a wake pulse is still in flight through the synchronizer while other inputs change, so the stop exit latency of three edges is exercised. A wake that arrives with `keep_min_clk` low must be dropped. Directed sequences are followed by a stretch of random strobes. Together they reach collisions the directed steps miss: a debug command against an interrupt in wait, wait against stop, and `dbg_en` toggling while in stop.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_WAIT = 2'b01,
    MODE_STOP = 2'b10,
    MODE_BKG  = 2'b11
  } lpm_mode_e;
endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2 >= 0 ? STAGES-2 : 0:0], din};
      end
      assign dout = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      boot_bkg,
  input  logic      wait_req,
  input  logic      stop_req,
  input  logic      irq_pend,
  input  logic      ext_wake_s,
  input  logic      tick_wake_s,
  input  logic      bdm_cmd,
  input  logic      bkg_go,
  input  logic      dbg_en,
  input  logic      keep_min_clk,
  output lpm_mode_e mode_q,
  output lpm_mode_e mode_nxt,
  output logic      wait_entry
);
  logic bkg_req;
  assign bkg_req = bdm_cmd & dbg_en;

  always_comb begin
    mode_nxt   = mode_q;
    wait_entry = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (wait_req) begin
          mode_nxt   = MODE_WAIT;
          wait_entry = 1'b1;
        end else if (stop_req) begin
          mode_nxt = MODE_STOP;
        end else if (bkg_req) begin
          mode_nxt = MODE_BKG;
        end
      end
      MODE_WAIT: begin
        if (bkg_req)       mode_nxt = MODE_BKG;
        else if (irq_pend) mode_nxt = MODE_RUN;
      end
      MODE_STOP: begin
        if (ext_wake_s || (tick_wake_s && keep_min_clk)) mode_nxt = MODE_RUN;
      end
      MODE_BKG: begin
        if (bkg_go) mode_nxt = MODE_RUN;
      end
      default: mode_nxt = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= boot_bkg ? MODE_BKG : MODE_RUN;
    else     mode_q <= mode_nxt;
  end
endmodule

// File: rtl/lpm_mask_reg.sv
module lpm_mask_reg (
  input  logic clk,
  input  logic rst,
  input  logic wait_entry,
  input  logic mask_set,
  input  logic mask_clr,
  output logic mask_q
);
  always_ff @(posedge clk) begin
    if (rst)             mask_q <= 1'b1;
    else if (wait_entry) mask_q <= 1'b0;
    else if (mask_set)   mask_q <= 1'b1;
    else if (mask_clr)   mask_q <= 1'b0;
  end
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lpm_mode_e mode_nxt,
  input  logic      dbg_en,
  input  logic      keep_min_clk,
  output logic      cpu_clk_en,
  output logic      per_clk_en,
  output logic      osc_en,
  output logic      min_clk_en
);
  logic halting;
  assign halting = (mode_nxt == MODE_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      min_clk_en <= 1'b1;
    end else begin
      cpu_clk_en <= (mode_nxt == MODE_RUN) || (mode_nxt == MODE_BKG);
      per_clk_en <= !halting;
      osc_en     <= !halting || dbg_en;
      min_clk_en <= !halting || dbg_en || keep_min_clk;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int WAKE_SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       boot_bkg,
  input  logic       wait_req,
  input  logic       stop_req,
  input  logic       irq_pend,
  input  logic       ext_wake,
  input  logic       tick_wake,
  input  logic       bdm_cmd,
  input  logic       bkg_go,
  input  logic       dbg_en,
  input  logic       keep_min_clk,
  input  logic       mask_set,
  input  logic       mask_clr,
  output logic [1:0] mode,
  output logic       mask_bit,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       min_clk_en
);
  import lpm_pkg::*;

  localparam int NUM_WAKE = 2;

  logic [NUM_WAKE-1:0] wake_raw, wake_s;
  lpm_mode_e           mode_q, mode_nxt;
  logic                wait_entry;

  assign wake_raw = {tick_wake, ext_wake};

  for (genvar gi = 0; gi < NUM_WAKE; gi++) begin : g_sync
    lpm_wake_sync #(.STAGES(WAKE_SYNC)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (wake_raw[gi]),
      .dout (wake_s[gi])
    );
  end

  lpm_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .boot_bkg     (boot_bkg),
    .wait_req     (wait_req),
    .stop_req     (stop_req),
    .irq_pend     (irq_pend),
    .ext_wake_s   (wake_s[0]),
    .tick_wake_s  (wake_s[1]),
    .bdm_cmd      (bdm_cmd),
    .bkg_go       (bkg_go),
    .dbg_en       (dbg_en),
    .keep_min_clk (keep_min_clk),
    .mode_q       (mode_q),
    .mode_nxt     (mode_nxt),
    .wait_entry   (wait_entry)
  );

  lpm_mask_reg u_mask (
    .clk        (clk),
    .rst        (rst),
    .wait_entry (wait_entry),
    .mask_set   (mask_set),
    .mask_clr   (mask_clr),
    .mask_q     (mask_bit)
  );

  lpm_clk_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .mode_nxt     (mode_nxt),
    .dbg_en       (dbg_en),
    .keep_min_clk (keep_min_clk),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .osc_en       (osc_en),
    .min_clk_en   (min_clk_en)
  );

  assign mode = mode_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wait_req,
  input logic       irq_pend,
  input logic       bdm_cmd,
  input logic       bkg_go,
  input logic       dbg_en,
  input logic [1:0] mode,
  input logic       mask_bit,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_en
);
  p_wait_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && wait_req) |=> (mode == 2'b01 && !mask_bit && !cpu_clk_en && per_clk_en));

  p_wait_irq_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && irq_pend && !bdm_cmd) |=> (mode == 2'b00 && cpu_clk_en));

  p_bkg_needs_dbg_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && bdm_cmd && !dbg_en && !irq_pend) |=> (mode == 2'b01));

  p_stop_osc_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !cpu_clk_en) |-> (osc_en == $past(dbg_en)));

  p_stop_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (mode == 2'b10 || mode == 2'b00));

  p_bkg_cpu_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !bkg_go) |=> (mode == 2'b11 && cpu_clk_en));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wait_req   (wait_req),
  .irq_pend   (irq_pend),
  .bdm_cmd    (bdm_cmd),
  .bkg_go     (bkg_go),
  .dbg_en     (dbg_en),
  .mode       (mode),
  .mask_bit   (mask_bit),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .osc_en     (osc_en)
);

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;
  localparam int WS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boot_bkg = 0, wait_req = 0, stop_req = 0, irq_pend = 0;
  logic ext_wake = 0, tick_wake = 0, bdm_cmd = 0, bkg_go = 0;
  logic dbg_en = 0, keep_min_clk = 0, mask_set = 0, mask_clr = 0;
  logic [1:0] mode;
  logic mask_bit, cpu_clk_en, per_clk_en, osc_en, min_clk_en;

  always #2.5 clk = ~clk;

  lpm_ctrl #(.WAKE_SYNC(WS)) u_dut (
    .clk(clk), .rst(rst), .boot_bkg(boot_bkg), .wait_req(wait_req),
    .stop_req(stop_req), .irq_pend(irq_pend), .ext_wake(ext_wake),
    .tick_wake(tick_wake), .bdm_cmd(bdm_cmd), .bkg_go(bkg_go),
    .dbg_en(dbg_en), .keep_min_clk(keep_min_clk), .mask_set(mask_set),
    .mask_clr(mask_clr), .mode(mode), .mask_bit(mask_bit),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .min_clk_en(min_clk_en)
  );

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";
  bit checking = 0;

  int m_mode, m_mask, m_cpu, m_per, m_osc, m_min;
  int ew_q[WS], tw_q[WS];

  // Behavioural reference, advanced at each rising edge.
  always @(posedge clk) begin
    int nm, ews, tws;
    if (rst) begin
      m_mode = boot_bkg ? 3 : 0;
      m_mask = 1; m_cpu = 1; m_per = 1; m_osc = 1; m_min = 1;
      for (int i = 0; i < WS; i++) begin ew_q[i] = 0; tw_q[i] = 0; end
    end else begin
      ews = ew_q[WS-1]; tws = tw_q[WS-1];
      nm = m_mode;
      case (m_mode)
        0: if (wait_req) nm = 1; else if (stop_req) nm = 2;
           else if (bdm_cmd && dbg_en) nm = 3;
        1: if (bdm_cmd && dbg_en) nm = 3; else if (irq_pend) nm = 0;
        2: if (ews != 0 || (tws != 0 && keep_min_clk)) nm = 0;
        default: if (bkg_go) nm = 0;
      endcase
      if (m_mode == 0 && wait_req) m_mask = 0;
      else if (mask_set) m_mask = 1;
      else if (mask_clr) m_mask = 0;
      m_cpu = (nm == 0 || nm == 3) ? 1 : 0;
      m_per = (nm != 2) ? 1 : 0;
      m_osc = (nm != 2 || dbg_en) ? 1 : 0;
      m_min = (nm != 2 || dbg_en || keep_min_clk) ? 1 : 0;
      m_mode = nm;
      for (int i = WS-1; i > 0; i--) begin ew_q[i] = ew_q[i-1]; tw_q[i] = tw_q[i-1]; end
      ew_q[0] = ext_wake; tw_q[0] = tick_wake;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk("mode", int'(mode), m_mode);
      chk("mask_bit", int'(mask_bit), m_mask);
      chk("cpu_clk_en", int'(cpu_clk_en), m_cpu);
      chk("per_clk_en", int'(per_clk_en), m_per);
      chk("osc_en", int'(osc_en), m_osc);
      chk("min_clk_en", int'(min_clk_en), m_min);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_strobes();
    wait_req = 0; stop_req = 0; bdm_cmd = 0; bkg_go = 0;
    mask_set = 0; mask_clr = 0; irq_pend = 0; ext_wake = 0; tick_wake = 0;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state, normal boot
    tag = "R1";
    cyc(3); checking = 1; cyc(1);
    chk("R1 mode after reset", int'(mode), 0);
    rst = 0; cyc(2);
    // R1 / R8: reset into background, then resume
    rst = 1; boot_bkg = 1; cyc(2);
    chk("R1 boot into background", int'(mode), 3);
    rst = 0; boot_bkg = 0; tag = "R8"; cyc(3);
    chk("R8 held in background", int'(mode), 3);
    bkg_go = 1; cyc(1); bkg_go = 0; cyc(1);
    chk("R8 resume", int'(mode), 0);
    // R2: wait beats stop
    tag = "R2";
    wait_req = 1; stop_req = 1; mask_set = 1; cyc(1); clear_strobes(); cyc(1);
    chk("R2 wait entered", int'(mode), 1);
    chk("R2 cpu off", int'(cpu_clk_en), 0);
    chk("R9 wait clears mask over set", int'(mask_bit), 0);
    // R4: debug command ignored without enable
    tag = "R4";
    bdm_cmd = 1; cyc(2); bdm_cmd = 0;
    chk("R4 ignored without dbg_en", int'(mode), 1);
    // R3: interrupt wakes wait
    tag = "R3";
    irq_pend = 1; cyc(1); irq_pend = 0; cyc(1);
    chk("R3 back to run", int'(mode), 0);
    chk("R3 cpu on", int'(cpu_clk_en), 1);
    // R4: debug beats interrupt in wait
    tag = "R4";
    wait_req = 1; cyc(1); wait_req = 0; cyc(1);
    dbg_en = 1; bdm_cmd = 1; irq_pend = 1; cyc(1); clear_strobes(); cyc(1);
    chk("R4 background from wait", int'(mode), 3);
    tag = "R8"; bkg_go = 1; cyc(1); bkg_go = 0; dbg_en = 0; cyc(1);
    // R5 / R6: plain stop, irq ignored, external wake
    tag = "R5";
    stop_req = 1; cyc(1); stop_req = 0; cyc(1);
    chk("R5 stop entered", int'(mode), 2);
    chk("R5 osc off", int'(osc_en), 0);
    chk("R5 min off", int'(min_clk_en), 0);
    tag = "R6";
    irq_pend = 1; cyc(4); irq_pend = 0;
    chk("R6 irq ignored in stop", int'(mode), 2);
    ext_wake = 1; cyc(1); ext_wake = 0; cyc(WS);
    chk("R6 ext wake latency", int'(mode), 0);
    // R7: tick ignored without option, honoured with it
    tag = "R7";
    stop_req = 1; cyc(1); stop_req = 0;
    tick_wake = 1; cyc(1); tick_wake = 0; cyc(WS + 2);
    chk("R7 tick ignored", int'(mode), 2);
    keep_min_clk = 1; tag = "R10"; cyc(1);
    chk("R10 min follows option", int'(min_clk_en), 1);
    dbg_en = 1; cyc(1);
    chk("R10 osc follows dbg_en", int'(osc_en), 1);
    dbg_en = 0; tag = "R7";
    tick_wake = 1; cyc(1); tick_wake = 0; cyc(WS);
    chk("R7 tick wakes", int'(mode), 0);
    keep_min_clk = 0;
    // R9: mask precedence
    tag = "R9";
    mask_set = 1; mask_clr = 1; cyc(1); clear_strobes();
    chk("R9 set wins", int'(mask_bit), 1);
    mask_clr = 1; cyc(1); mask_clr = 0;
    chk("R9 clear", int'(mask_bit), 0);
    // random phase
    tag = "R10";
    for (int k = 0; k < 400; k++) begin
      wait_req = ($urandom_range(9) == 0); stop_req = ($urandom_range(9) == 0);
      irq_pend = ($urandom_range(5) == 0); ext_wake = ($urandom_range(12) == 0);
      tick_wake = ($urandom_range(6) == 0); bdm_cmd = ($urandom_range(11) == 0);
      bkg_go = ($urandom_range(4) == 0); mask_set = ($urandom_range(7) == 0);
      mask_clr = ($urandom_range(7) == 0);
      if ($urandom_range(15) == 0) dbg_en = ~dbg_en;
      if ($urandom_range(15) == 0) keep_min_clk = ~keep_min_clk;
      cyc(1);
    end
    clear_strobes(); cyc(2);
    checking = 0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule